// File: doc/BRIEF.md
# Dual-Style Parallel Host Register Port

This block lets a host microprocessor read and write a small register file over a parallel bus. A static strap chooses one of two signalling conventions. In the first, separate active-low read and write strobes are used. In the second, a read/write select is paired with one active-low data strobe. An address latch enable input covers both address bus types. While it is held high the address path is transparent, which suits a non-multiplexed bus. When it falls, the address is captured, which suits a multiplexed bus.

The bus pins are asynchronous to the system clock. Each is passed through a two-flop synchroniser before any decision is made. A write commits once, when its strobe is released. The 8-bit data bus is split into an input, an output and an output enable. Behind the port sit three kinds of register: a latched event status register whose bits are cleared by writing 1, an enable mask for those events, and general scratch registers. An active-low open-drain interrupt line is pulled low while any unmasked status bit is set.

Top module: `cpu_regport`

## Requirements
- R1: With `bus_mode`=0, holding `cs_n` low and pulsing `wr_rw` low then high writes `din` to the register selected by the current address. The write commits after the strobe goes back high.
- R2: With `bus_mode`=1, holding `cs_n` low and `wr_rw`=0, then pulsing `rd_ds` low and back high, writes `din` to the selected register. The write commits on the rising edge of `rd_ds`.
- R3: `doe` is 1 only during a read. In both modes a read is `cs_n`=0, `rd_ds`=0 and `wr_rw`=1. During a read, `dout` carries the selected register. At all other times `doe`=0 and `dout`=0x00, including during writes.
- R4: While `cs_n` is high, strobes cause no register write and no drive of the data bus.
- R5: While `ale`=1 the address input is used directly. When `ale` falls, the address present at that moment is held, and later changes on `addr` are ignored until `ale` rises again.
- R6: A write takes effect only when its strobe is released. A status event that arrives while a clearing write strobe is still held is cleared by that write. An event that arrives after the release stays set.
- R7: With `bus_mode`=0, asserting `wr_rw` and `rd_ds` low together neither writes nor drives the data bus.
- R8: Status register at address 0: bit i is set by a clock cycle with `irq_evt[i]`=1. Writing a 1 to a bit clears it. A set in the same cycle as a clear wins.
- R9: Mask register at address 1, where 1 enables a source. `irq_oe`=1 exactly while some status bit and its mask bit are both 1, so clearing the bit or masking it releases the line. `irq_pin` is always 0.
- R10: Scratch registers sit at addresses 2 to 2+NSCR-1 and are read/write. Reads of any other address return 0x00, and writes there have no effect.
- R11: After reset every register reads 0x00, and `doe`=0, `dout`=0x00 and `irq_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_mode | input | 1 | Static strap: 0 = separate strobes, 1 = select plus data strobe |
| ale | input | 1 | Address latch enable: high = transparent, falling edge = capture |
| cs_n | input | 1 | Active-low chip select |
| wr_rw | input | 1 | Mode 0: active-low write strobe. Mode 1: read/write select (1 = read) |
| rd_ds | input | 1 | Mode 0: active-low read strobe. Mode 1: active-low data strobe |
| addr | input | AW | Register address |
| din | input | 8 | Write data from the host |
| dout | output | 8 | Read data to the host, 0 when not driving |
| doe | output | 1 | Data bus output enable |
| irq_evt | input | NSRC | Synchronous event pulses that set status bits |
| irq_oe | output | 1 | Open-drain enable for the interrupt line |
| irq_pin | output | 1 | Interrupt line value, constant 0 |

## Verification
The bench targets overlapping strobes in the first mode. A design that decodes each strobe on its own would write and drive at the same time. It holds a clearing write open while an event arrives. A design that commits at the start of the strobe would leave that event set. It moves the address bus after `ale` falls, which catches a latch that is still transparent. It also strobes with chip select high and reads unmapped addresses, which expose a missing select gate or a read mux that wraps.

// File: rtl/cpu_regport.sv
module cpu_regport #(
  parameter int AW   = 4,
  parameter int NSRC = 8,
  parameter int NSCR = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_mode,
  input  logic            ale,
  input  logic            cs_n,
  input  logic            wr_rw,
  input  logic            rd_ds,
  input  logic [AW-1:0]   addr,
  input  logic [7:0]      din,
  output logic [7:0]      dout,
  output logic            doe,
  input  logic [NSRC-1:0] irq_evt,
  output logic            irq_oe,
  output logic            irq_pin
);
  localparam int SCR_BASE = 2;

  logic [1:0] cs_q, wr_q, rd_q, ale_q;
  logic [AW-1:0] a1, a2, lat_addr, wa_q;
  logic [7:0] d1, d2, wd_q;
  logic wact_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 2'b11; wr_q <= 2'b11; rd_q <= 2'b11; ale_q <= 2'b11;
      a1 <= '0; a2 <= '0; d1 <= '0; d2 <= '0;
    end else begin
      cs_q  <= {cs_q[0], cs_n};
      wr_q  <= {wr_q[0], wr_rw};
      rd_q  <= {rd_q[0], rd_ds};
      ale_q <= {ale_q[0], ale};
      a1 <= addr; a2 <= a1;
      d1 <= din;  d2 <= d1;
    end
  end

  wire cs_s  = cs_q[1];
  wire wr_s  = wr_q[1];
  wire rd_s  = rd_q[1];
  wire ale_s = ale_q[1];

  wire [AW-1:0] eff = ale_s ? a2 : lat_addr;

  wire wact = ~cs_s & ~(bus_mode ? rd_s : wr_s) & (bus_mode ? ~wr_s : rd_s);
  wire ract = ~cs_s & ~rd_s & wr_s;
  wire stb_s = bus_mode ? rd_s : wr_s;
  wire wr_fire = wact_q & stb_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_addr <= '0; wa_q <= '0; wd_q <= '0; wact_q <= 1'b0;
    end else begin
      if (ale_s) lat_addr <= a2;
      wact_q <= wact;
      if (wact) begin
        wa_q <= eff;
        wd_q <= d2;
      end
    end
  end

  logic [NSRC-1:0] stat, mask;
  logic [NSCR-1:0][7:0] scr;

  wire [NSRC-1:0] clr = (wr_fire && wa_q == AW'(0)) ? wd_q[NSRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0; mask <= '0; scr <= '0;
    end else begin
      stat <= (stat & ~clr) | irq_evt;
      if (wr_fire && wa_q == AW'(1)) mask <= wd_q[NSRC-1:0];
      for (int i = 0; i < NSCR; i++)
        if (wr_fire && wa_q == AW'(SCR_BASE + i)) scr[i] <= wd_q;
    end
  end

  logic [7:0] rdata;
  always_comb begin
    rdata = 8'h00;
    if (eff == AW'(0)) rdata = 8'(stat);
    if (eff == AW'(1)) rdata = 8'(mask);
    for (int i = 0; i < NSCR; i++)
      if (eff == AW'(SCR_BASE + i)) rdata = scr[i];
  end

  assign doe     = ract;
  assign dout    = ract ? rdata : 8'h00;
  assign irq_oe  = |(stat & mask);
  assign irq_pin = 1'b0;
endmodule

module cpu_regport_chk #(
  parameter int NSRC = 8,
  parameter int NSCR = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cs_n,
  input logic            doe,
  input logic [NSRC-1:0] irq_evt,
  input logic [NSRC-1:0] stat,
  input logic [NSCR-1:0][7:0] scr,
  input logic            wr_fire
);
  assert_drive_needs_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    doe |-> !$past(cs_n, 2));
  assert_write_needs_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> !$past(cs_n, 3));
  assert_single_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !wr_fire);
  assert_evt_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_evt) |=> ((stat & $past(irq_evt)) == $past(irq_evt)));
  assert_scr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(scr));
endmodule

bind cpu_regport cpu_regport_chk #(.NSRC(NSRC), .NSCR(NSCR)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .doe(doe), .irq_evt(irq_evt),
  .stat(stat), .scr(scr), .wr_fire(wr_fire)
);

// File: tb/sim_cpu_regport.sv
module sim_cpu_regport;
  logic clk = 0, rst_n = 0;
  logic bus_mode = 0, ale = 1, cs_n = 1, wr_rw = 1, rd_ds = 1;
  logic [3:0] addr = 0;
  logic [7:0] din = 0;
  logic [7:0] irq_evt = 0;
  wire [7:0] dout;
  wire doe, irq_oe, irq_pin;
  int total = 0, bad = 0;
  logic [7:0] expq[$];
  string tagq[$];
  logic prev_doe = 0;

  always #2.5 clk = ~clk;

  cpu_regport u0 (.clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .ale(ale),
    .cs_n(cs_n), .wr_rw(wr_rw), .rd_ds(rd_ds), .addr(addr), .din(din),
    .dout(dout), .doe(doe), .irq_evt(irq_evt), .irq_oe(irq_oe), .irq_pin(irq_pin));

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor: each new drive of the data bus is compared to the next expected read
  always @(negedge clk) begin
    if (rst_n && doe && !prev_doe) begin
      total++;
      if (expq.size() == 0) begin
        bad++;
        $display("FAIL R3: actual=%h expected=no drive", dout);
      end else begin
        string t;
        logic [7:0] e;
        e = expq.pop_front();
        t = tagq.pop_front();
        if (dout !== e) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", t, dout, e);
        end
      end
    end
    prev_doe = doe;
  end

  task automatic bus_wr(logic [3:0] a, logic [7:0] d, bit seta, string tag);
    if (seta) addr = a;
    din = d; cs_n = 0;
    if (bus_mode) wr_rw = 0;
    cyc(3);
    if (bus_mode) rd_ds = 0; else wr_rw = 0;
    cyc(4);
    @(negedge clk) chk({tag, " R3 no drive on write"}, {7'b0, doe}, 8'h00);
    cyc(1);
    if (bus_mode) rd_ds = 1; else wr_rw = 1;
    cyc(4);
    if (bus_mode) wr_rw = 1;
    cs_n = 1;
    cyc(3);
  endtask

  task automatic bus_rd(logic [3:0] a, logic [7:0] e, bit seta, string tag);
    if (seta) addr = a;
    cs_n = 0; wr_rw = 1;
    cyc(3);
    expq.push_back(e); tagq.push_back(tag);
    rd_ds = 0;
    cyc(5);
    rd_ds = 1;
    cyc(4);
    cs_n = 1;
    cyc(3);
  endtask

  task automatic pulse_evt(logic [7:0] v);
    irq_evt = v; cyc(1); irq_evt = 0; cyc(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(2);
    @(negedge clk);
    chk("R11 doe", {7'b0, doe}, 8'h00);
    chk("R11 dout", dout, 8'h00);
    chk("R11 irq_oe", {7'b0, irq_oe}, 8'h00);
    for (int i = 0; i < 6; i++) bus_rd(4'(i), 8'h00, 1, "R11 reset value");

    bus_wr(4'd2, 8'hA5, 1, "R1");
    bus_rd(4'd2, 8'hA5, 1, "R1 write/read");
    bus_wr(4'd3, 8'h5A, 1, "R10");
    bus_wr(4'd4, 8'h11, 1, "R10");
    bus_wr(4'd5, 8'hC3, 1, "R10");
    bus_wr(4'd9, 8'hEE, 1, "R10");
    bus_rd(4'd3, 8'h5A, 1, "R10 scratch3");
    bus_rd(4'd4, 8'h11, 1, "R10 scratch4");
    bus_rd(4'd5, 8'hC3, 1, "R10 scratch5");
    bus_rd(4'd6, 8'h00, 1, "R10 unmapped 6");
    bus_rd(4'd9, 8'h00, 1, "R10 unmapped 9");
    bus_rd(4'd15, 8'h00, 1, "R10 unmapped 15");

    // R4: strobes with chip select high
    addr = 4'd3; din = 8'hFF; wr_rw = 0; cyc(5); wr_rw = 1; cyc(5);
    rd_ds = 0; cyc(5);
    @(negedge clk) chk("R4 no drive without cs", {7'b0, doe}, 8'h00);
    cyc(1); rd_ds = 1; cyc(4);
    bus_rd(4'd3, 8'h5A, 1, "R4 no write without cs");

    // R7: both strobes at once in mode 0
    addr = 4'd4; din = 8'h99; cs_n = 0; cyc(3);
    wr_rw = 0; rd_ds = 0; cyc(5);
    @(negedge clk) chk("R7 no drive on overlap", {7'b0, doe}, 8'h00);
    cyc(1); wr_rw = 1; rd_ds = 1; cyc(5); cs_n = 1; cyc(3);
    bus_rd(4'd4, 8'h11, 1, "R7 no write on overlap");

    // R5: multiplexed address
    addr = 4'd4; ale = 1; cyc(4); ale = 0; cyc(4); addr = 4'd5;
    bus_wr(4'd0, 8'h3C, 0, "R5");
    addr = 4'd2; ale = 1; cyc(4); ale = 0; cyc(4); addr = 4'd7;
    bus_rd(4'd0, 8'hA5, 0, "R5 latched read");
    ale = 1; cyc(4);
    bus_rd(4'd4, 8'h3C, 1, "R5 latched write target");
    bus_rd(4'd5, 8'hC3, 1, "R5 other reg untouched");

    // R2: second signalling style
    bus_mode = 1; cyc(2);
    bus_wr(4'd5, 8'h77, 1, "R2");
    bus_rd(4'd5, 8'h77, 1, "R2 write/read");
    bus_rd(4'd2, 8'hA5, 1, "R2 read");

    // R8 / R9
    pulse_evt(8'h04);
    bus_rd(4'd0, 8'h04, 1, "R8 status set");
    @(negedge clk) chk("R9 masked off", {7'b0, irq_oe}, 8'h00);
    bus_wr(4'd1, 8'h04, 1, "R9");
    @(negedge clk) chk("R9 unmasked asserts", {7'b0, irq_oe}, 8'h01);
    chk("R9 pin low", {7'b0, irq_pin}, 8'h00);
    bus_wr(4'd1, 8'h00, 1, "R9");
    @(negedge clk) chk("R9 masking releases", {7'b0, irq_oe}, 8'h00);
    bus_wr(4'd1, 8'h04, 1, "R9");
    pulse_evt(8'h20);
    bus_wr(4'd0, 8'h20, 1, "R8");
    bus_rd(4'd0, 8'h04, 1, "R8 w1c one bit");
    @(negedge clk) chk("R9 still active", {7'b0, irq_oe}, 8'h01);
    bus_wr(4'd0, 8'h04, 1, "R8");
    @(negedge clk) chk("R9 clear releases", {7'b0, irq_oe}, 8'h00);
    bus_rd(4'd0, 8'h00, 1, "R8 cleared");

    // R6: commit happens at strobe release
    bus_mode = 0; cyc(2);
    addr = 4'd0; din = 8'h08; cs_n = 0; cyc(3);
    wr_rw = 0; cyc(4);
    pulse_evt(8'h08);
    cyc(2); wr_rw = 1; cyc(5); cs_n = 1; cyc(3);
    bus_rd(4'd0, 8'h00, 1, "R6 event during strobe cleared");
    pulse_evt(8'h08);
    bus_rd(4'd0, 8'h08, 1, "R6 event after release kept");

    cyc(5);
    chk("R3 all reads seen", 8'(expq.size()), 8'h00);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule